// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the core of a small CPU subsystem runs, naps or loses power. Software programs two registers over a memory-mapped bus that accepts only 32-bit accesses. The first is a mode-select register with a light-sleep-or-deep choice. The second holds a resume address. When the CPU raises its one-cycle sleep request, the block enters one of two low-power states. In nap mode the core clock is gated while the peripherals and the external clock output keep running. In retention standby the core power is cut.

Leaving retention standby takes a fixed sequence. The core is powered up and held in a core-only reset. The block waits a programmable PLL-settle time and then re-enables the clock. A one-cycle restore pulse tells the backup registers to reload. Last comes a vector strobe that releases the core at its start address. The start address is the programmed resume address for an interrupt wake, and a fixed vector for a system-reset wake. The block records the interrupt sources that caused the wake until the strobe has gone out.

Top module: `lpm_sequencer`

## Requirements
- R1: The mode register sits at offset 0x0. Bit 7 is the standby-select bit and bit 5 is the retention bit. Every other bit reads 0 and discards writes.
- R2: A write to the mode register with bits 7 and 5 both set is rejected, and the register keeps its old value.
- R3: The resume-address register sits at offset 0x4 and takes all 32 bits. Accesses with a size code other than 2'b10 (longword) write nothing and read 0.
- R4: A sleep request with both mode bits clear enters nap mode on the next cycle: `core_clk_en` goes low and `clkout_en` stays high.
- R5: Nap mode returns to run on the cycle after any interrupt input (including `irq_periph`) or `sys_rst_req` is seen.
- R6: A sleep request with only bit 5 set enters retention standby on the next cycle. `core_pwr_off` goes high, both clock enables go low and `lp_status` reads 2'b11. `pd_status` rises one cycle later.
- R7: A sleep request while bit 7 is set is ignored, and the core keeps running.
- R8: In retention standby only `irq_nmi`, `irq_ext`, `irq_timer`, `irq_keyscan` and `irq_rtc` wake the block. `irq_periph` has no effect.
- R9: On wake, `core_pwr_off` drops and `core_rst` rises. Both clock enables stay low and `lp_status` stays 2'b11 for SETTLE_CYC+1 cycles.
- R10: After an interrupt wake, `restore_req` pulses for one cycle with the clocks on and `lp_status` at 2'b00. The next cycle carries `wake_vec_vld` with `wake_vec` equal to the resume address, and `core_rst` low.
- R11: A `sys_rst_req` in retention standby wakes the block with no restore pulse, and the vector is 0xA0000000. A reset wins over an interrupt that arrives in the same cycle.
- R12: `wake_src` records the waking interrupts with bit 0 for nmi, 1 for ext, 2 for timer, 3 for keyscan and 4 for rtc. It holds them through the vector-strobe cycle and clears them on the cycle after.
- R13: Waking does not clear the mode register.
- R14: `rst` returns the block to run mode with both registers at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| sys_rst_req | input | 1 | System reset request, wakes from a low-power state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_size | input | 2 | Access size code, 2'b10 is longword |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| irq_nmi | input | 1 | Non-maskable interrupt |
| irq_ext | input | 1 | External interrupt line |
| irq_periph | input | 1 | Interrupt from an ordinary peripheral |
| irq_timer | input | 1 | Always-on timer interrupt |
| irq_keyscan | input | 1 | Keyscan interrupt |
| irq_rtc | input | 1 | Real-time clock interrupt |
| core_clk_en | output | 1 | Core clock enable |
| clkout_en | output | 1 | External clock output enable |
| core_pwr_off | output | 1 | Core power-off request |
| core_rst | output | 1 | Core-domain reset |
| lp_status | output | 2 | Pair of low-power status lines |
| pd_status | output | 1 | Core power is off |
| restore_req | output | 1 | Backup register reload pulse |
| wake_vec | output | 32 | Core start address, valid with the strobe |
| wake_vec_vld | output | 1 | Start address strobe |
| wake_src | output | 5 | Recorded waking interrupt sources |

## Verification
The bench builds the block with SETTLE_CYC set to 3, so each settle wait is four cycles. With such a short wait, several full enter-and-wake round trips fit in a short run, and the exact cycle on which the clock comes back can be checked. The default width of 4 address bits keeps both register offsets reachable. Several cases are placed on single cycles: a reset and an interrupt arriving together, two wake sources arriving together, and a rejected write to the mode register.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int          DATA_W       = 32;
    localparam int          NUM_RET_SRC  = 5;
    localparam int          BIT_SWSTBY   = 7;
    localparam int          BIT_RETSTBY  = 5;
    localparam logic [1:0]  SIZE_LONG    = 2'b10;
    localparam logic [31:0] RESET_VECTOR = 32'hA000_0000;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_RS_ENTER,
        ST_RS_OFF,
        ST_RS_SETTLE,
        ST_RS_RESTORE,
        ST_RS_VEC
    } lpm_state_e;

    typedef struct packed {
        logic sw_stby;
        logic ret_stby;
    } lpm_ctl_t;

    typedef struct packed {
        logic       core_clk_en;
        logic       clkout_en;
        logic       core_pwr_off;
        logic       core_rst;
        logic       pd_stat;
        logic       restore_req;
        logic       vec_vld;
        logic [1:0] stat;
    } lpm_out_t;

    // Output pattern driven in each sequencer state.
    function automatic lpm_out_t decode_state(lpm_state_e s);
        lpm_out_t o;
        o = '0;
        case (s)
            ST_RUN: begin
                o.core_clk_en = 1'b1;
                o.clkout_en   = 1'b1;
            end
            ST_SLEEP: begin
                o.clkout_en   = 1'b1;
            end
            ST_RS_ENTER: begin
                o.core_pwr_off = 1'b1;
                o.stat         = 2'b11;
            end
            ST_RS_OFF: begin
                o.core_pwr_off = 1'b1;
                o.pd_stat      = 1'b1;
                o.stat         = 2'b11;
            end
            ST_RS_SETTLE: begin
                o.core_rst = 1'b1;
                o.stat     = 2'b11;
            end
            ST_RS_RESTORE: begin
                o.core_clk_en = 1'b1;
                o.clkout_en   = 1'b1;
                o.core_rst    = 1'b1;
                o.restore_req = 1'b1;
            end
            ST_RS_VEC: begin
                o.core_clk_en = 1'b1;
                o.clkout_en   = 1'b1;
                o.vec_vld     = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

    // A mode write may select at most one low-power flavour.
    function automatic logic ctl_write_legal(logic [DATA_W-1:0] d);
        return !(d[BIT_SWSTBY] && d[BIT_RETSTBY]);
    endfunction

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
    import lpm_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CTL_OFS = 0,
    parameter int BAR_OFS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output lpm_ctl_t          ctl,
    output logic [DATA_W-1:0] boot_addr
);

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] BAR_A = ADDR_W'(BAR_OFS);

    logic long_acc;
    logic ctl_wr, bar_wr;
    lpm_ctl_t          ctl_q;
    logic [DATA_W-1:0] bar_q;
    logic [DATA_W-1:0] ctl_view;

    assign long_acc = (reg_size == SIZE_LONG);
    assign ctl_wr   = reg_wr && long_acc && (reg_addr == CTL_A);
    assign bar_wr   = reg_wr && long_acc && (reg_addr == BAR_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr && ctl_write_legal(reg_wdata)) begin
            ctl_q.sw_stby  <= reg_wdata[BIT_SWSTBY];
            ctl_q.ret_stby <= reg_wdata[BIT_RETSTBY];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q <= '0;
        end else if (bar_wr) begin
            bar_q <= reg_wdata;
        end
    end

    always_comb begin
        ctl_view              = '0;
        ctl_view[BIT_SWSTBY]  = ctl_q.sw_stby;
        ctl_view[BIT_RETSTBY] = ctl_q.ret_stby;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && long_acc) begin
            if (reg_addr == CTL_A)      reg_rdata = ctl_view;
            else if (reg_addr == BAR_A) reg_rdata = bar_q;
        end
    end

    assign ctl       = ctl_q;
    assign boot_addr = bar_q;

    AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[BIT_SWSTBY] && reg_wdata[BIT_RETSTBY]) |=> $stable(ctl_q)); // R2
    AST_CTL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.sw_stby && ctl_q.ret_stby)); // R2
    AST_SHORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !long_acc) |=> ($stable(bar_q) && $stable(ctl_q))); // R3

endmodule

// File: rtl/lpm_settle.sv
module lpm_settle #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

    AST_SETTLE_LOADED: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == LOAD_VAL)); // R9
    AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !done) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R9

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int          NSRC    = NUM_RET_SRC,
    parameter logic [31:0] RST_VEC = RESET_VECTOR
) (
    input  logic              clk,
    input  logic              rst,
    input  lpm_ctl_t          ctl,
    input  logic [DATA_W-1:0] boot_addr,
    input  logic              sleep_req,
    input  logic              sys_rst_req,
    input  logic [NSRC-1:0]   ret_wake,
    input  logic              sleep_wake,
    input  logic              settle_done,
    output logic              settle_load,
    output logic              settle_run,
    output lpm_out_t          outs,
    output logic [DATA_W-1:0] wake_vec,
    output logic [NSRC-1:0]   wake_src
);

    lpm_state_e state_q, state_d;
    logic       by_rst_q, by_rst_d;
    logic       take_irq_wake;

    assign take_irq_wake = (state_q == ST_RS_OFF) && !sys_rst_req && (|ret_wake);

    always_comb begin
        state_d     = state_q;
        by_rst_d    = by_rst_q;
        settle_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_req && !ctl.sw_stby)
                    state_d = ctl.ret_stby ? ST_RS_ENTER : ST_SLEEP;
            end
            ST_SLEEP: begin
                if (sys_rst_req || sleep_wake) state_d = ST_RUN;
            end
            ST_RS_ENTER: state_d = ST_RS_OFF;
            ST_RS_OFF: begin
                if (sys_rst_req) begin
                    state_d     = ST_RS_SETTLE;
                    by_rst_d    = 1'b1;
                    settle_load = 1'b1;
                end else if (|ret_wake) begin
                    state_d     = ST_RS_SETTLE;
                    by_rst_d    = 1'b0;
                    settle_load = 1'b1;
                end
            end
            ST_RS_SETTLE: begin
                if (settle_done) state_d = by_rst_q ? ST_RS_VEC : ST_RS_RESTORE;
            end
            ST_RS_RESTORE: state_d = ST_RS_VEC;
            ST_RS_VEC:     state_d = ST_RUN;
            default:       state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            by_rst_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            by_rst_q <= by_rst_d;
        end
    end

    // One pending flag per retention wake source.
    for (genvar i = 0; i < NSRC; i++) begin : g_pend
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst)                          pend_q <= 1'b0;
            else if (state_q == ST_RS_VEC)    pend_q <= 1'b0;
            else if (take_irq_wake && ret_wake[i]) pend_q <= 1'b1;
        end
        assign wake_src[i] = pend_q;
    end

    assign settle_run = (state_q == ST_RS_SETTLE);
    assign outs       = decode_state(state_q);
    assign wake_vec   = outs.vec_vld ? (by_rst_q ? RST_VEC : boot_addr) : '0;

    AST_PD_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.pd_stat) |-> $past(outs.core_pwr_off)); // R6
    AST_CLK_HELD: assert property (@(posedge clk) disable iff (rst)
        (settle_run && !settle_done) |-> (!outs.core_clk_en && outs.core_rst)); // R9
    AST_RESTORE_THEN_VEC: assert property (@(posedge clk) disable iff (rst)
        outs.restore_req |=> (outs.vec_vld && (wake_vec == boot_addr))); // R10
    AST_SRC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        outs.vec_vld |=> (wake_src == '0)); // R12
    AST_IGNORE_SWSTBY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && sleep_req && ctl.sw_stby) |=> (state_q == ST_RUN)); // R7
    AST_RESET_WAKE_VEC: assert property (@(posedge clk) disable iff (rst)
        (outs.vec_vld && by_rst_q) |-> (wake_vec == RST_VEC)); // R11

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CTL_OFS    = 0,
    parameter int BAR_OFS    = 4,
    parameter int SETTLE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_rst_req,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sleep_req,
    input  logic              irq_nmi,
    input  logic              irq_ext,
    input  logic              irq_periph,
    input  logic              irq_timer,
    input  logic              irq_keyscan,
    input  logic              irq_rtc,
    output logic              core_clk_en,
    output logic              clkout_en,
    output logic              core_pwr_off,
    output logic              core_rst,
    output logic [1:0]        lp_status,
    output logic              pd_status,
    output logic              restore_req,
    output logic [31:0]       wake_vec,
    output logic              wake_vec_vld,
    output logic [4:0]        wake_src
);

    lpm_ctl_t                ctl;
    logic [DATA_W-1:0]       boot_addr;
    logic [NUM_RET_SRC-1:0]  ret_wake;
    logic                    sleep_wake;
    logic                    settle_load, settle_run, settle_done;
    lpm_out_t                outs;

    assign ret_wake   = {irq_rtc, irq_keyscan, irq_timer, irq_ext, irq_nmi};
    assign sleep_wake = irq_periph || (|ret_wake);

    lpm_regs #(
        .ADDR_W (ADDR_W),
        .CTL_OFS(CTL_OFS),
        .BAR_OFS(BAR_OFS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_size (reg_size),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ctl      (ctl),
        .boot_addr(boot_addr)
    );

    lpm_settle #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_settle (
        .clk (clk),
        .rst (rst),
        .load(settle_load),
        .run (settle_run),
        .done(settle_done)
    );

    lpm_fsm #(
        .NSRC   (NUM_RET_SRC),
        .RST_VEC(RESET_VECTOR)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .boot_addr  (boot_addr),
        .sleep_req  (sleep_req),
        .sys_rst_req(sys_rst_req),
        .ret_wake   (ret_wake),
        .sleep_wake (sleep_wake),
        .settle_done(settle_done),
        .settle_load(settle_load),
        .settle_run (settle_run),
        .outs       (outs),
        .wake_vec   (wake_vec),
        .wake_src   (wake_src)
    );

    assign core_clk_en  = outs.core_clk_en;
    assign clkout_en    = outs.clkout_en;
    assign core_pwr_off = outs.core_pwr_off;
    assign core_rst     = outs.core_rst;
    assign lp_status    = outs.stat;
    assign pd_status    = outs.pd_stat;
    assign restore_req  = outs.restore_req;
    assign wake_vec_vld = outs.vec_vld;

    AST_NAP_KEEPS_CLKOUT: assert property (@(posedge clk) disable iff (rst)
        (!core_clk_en && !core_pwr_off && !core_rst) |-> clkout_en); // R4
    AST_NO_CLK_POWER_OFF: assert property (@(posedge clk) disable iff (rst)
        core_pwr_off |-> (!core_clk_en && !clkout_en && (lp_status == 2'b11))); // R6

endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;

    localparam int CLK_P  = 10;
    localparam int SETTLE = 3;

    localparam int M_RUN = 0, M_SLEEP = 1, M_ENTER = 2, M_OFF = 3,
                   M_SETTLE = 4, M_RESTORE = 5, M_VEC = 6;

    logic clk = 1'b0;
    logic rst, sys_rst_req, reg_wr, reg_rd, sleep_req;
    logic [3:0]  reg_addr;
    logic [1:0]  reg_size;
    logic [31:0] reg_wdata, reg_rdata, wake_vec;
    logic irq_nmi, irq_ext, irq_periph, irq_timer, irq_keyscan, irq_rtc;
    logic core_clk_en, clkout_en, core_pwr_off, core_rst, pd_status, restore_req, wake_vec_vld;
    logic [1:0] lp_status;
    logic [4:0] wake_src;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // behavioural model state
    int          ms;
    bit          mc7, mc5, mbyrst;
    logic [31:0] mbar;
    int          mcnt;
    logic [4:0]  mpend;

    always #(CLK_P/2) clk = ~clk;

    lpm_sequencer #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst(rst), .sys_rst_req(sys_rst_req),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
        .irq_nmi(irq_nmi), .irq_ext(irq_ext), .irq_periph(irq_periph),
        .irq_timer(irq_timer), .irq_keyscan(irq_keyscan), .irq_rtc(irq_rtc),
        .core_clk_en(core_clk_en), .clkout_en(clkout_en), .core_pwr_off(core_pwr_off),
        .core_rst(core_rst), .lp_status(lp_status), .pd_status(pd_status),
        .restore_req(restore_req), .wake_vec(wake_vec), .wake_vec_vld(wake_vec_vld),
        .wake_src(wake_src)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model's view of the current cycle.
    task automatic compare();
        logic ce, co, po, cr, pd, rq, vv;
        logic [1:0] st;
        logic [31:0] ev, erd;
        ce = 0; co = 0; po = 0; cr = 0; pd = 0; rq = 0; vv = 0; st = 2'b00; ev = 0;
        case (ms)
            M_RUN:     begin ce = 1; co = 1; end
            M_SLEEP:   begin co = 1; end
            M_ENTER:   begin po = 1; st = 2'b11; end
            M_OFF:     begin po = 1; pd = 1; st = 2'b11; end
            M_SETTLE:  begin cr = 1; st = 2'b11; end
            M_RESTORE: begin ce = 1; co = 1; cr = 1; rq = 1; end
            M_VEC:     begin ce = 1; co = 1; vv = 1; ev = mbyrst ? 32'hA000_0000 : mbar; end
            default:   ;
        endcase
        erd = 0;
        if (reg_rd && reg_size == 2'b10) begin
            if (reg_addr == 4'h0)      erd = {24'd0, mc7, 1'b0, mc5, 5'd0};
            else if (reg_addr == 4'h4) erd = mbar;
        end
        chk("R4", "core_clk_en", 32'(core_clk_en), 32'(ce));
        chk("R4", "clkout_en", 32'(clkout_en), 32'(co));
        chk("R6", "core_pwr_off", 32'(core_pwr_off), 32'(po));
        chk("R9", "core_rst", 32'(core_rst), 32'(cr));
        chk("R6", "lp_status", 32'(lp_status), 32'(st));
        chk("R6", "pd_status", 32'(pd_status), 32'(pd));
        chk("R10", "restore_req", 32'(restore_req), 32'(rq));
        chk("R10", "wake_vec_vld", 32'(wake_vec_vld), 32'(vv));
        chk("R10", "wake_vec", wake_vec, ev);
        chk("R12", "wake_src", 32'(wake_src), 32'(mpend));
        chk("R1", "reg_rdata", reg_rdata, erd);
    endtask

    task automatic model_edge();
        bit c7, c5;
        logic [4:0] wk;
        if (rst) begin
            ms = M_RUN; mc7 = 0; mc5 = 0; mbar = 0; mcnt = 0; mpend = 0; mbyrst = 0;
            return;
        end
        c7 = mc7; c5 = mc5;
        wk = {irq_rtc, irq_keyscan, irq_timer, irq_ext, irq_nmi};
        case (ms)
            M_RUN: if (sleep_req) begin
                if (!c7 && !c5) ms = M_SLEEP;
                else if (c5 && !c7) ms = M_ENTER;
            end
            M_SLEEP: if (sys_rst_req || wk != 0 || irq_periph) ms = M_RUN;
            M_ENTER: ms = M_OFF;
            M_OFF: begin
                if (sys_rst_req) begin
                    ms = M_SETTLE; mbyrst = 1; mcnt = SETTLE;
                end else if (wk != 0) begin
                    ms = M_SETTLE; mbyrst = 0; mcnt = SETTLE; mpend = wk;
                end
            end
            M_SETTLE: begin
                if (mcnt == 0) ms = mbyrst ? M_VEC : M_RESTORE;
                else mcnt--;
            end
            M_RESTORE: ms = M_VEC;
            M_VEC: begin ms = M_RUN; mpend = 0; end
            default: ms = M_RUN;
        endcase
        if (reg_wr && reg_size == 2'b10 && reg_addr == 4'h0 && !(reg_wdata[7] && reg_wdata[5])) begin
            mc7 = reg_wdata[7]; mc5 = reg_wdata[5];
        end
        if (reg_wr && reg_size == 2'b10 && reg_addr == 4'h4) mbar = reg_wdata;
    endtask

    task automatic tick();
        #(CLK_P/4);
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        sys_rst_req = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_size = 2'b10;
        reg_wdata = 0; sleep_req = 0; irq_nmi = 0; irq_ext = 0; irq_periph = 0;
        irq_timer = 0; irq_keyscan = 0; irq_rtc = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic [1:0] sz);
        reg_wr = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
        tick();
        reg_wr = 0; reg_size = 2'b10;
    endtask

    task automatic rd_expect(logic [3:0] a, logic [1:0] sz, logic [31:0] exp, string req);
        reg_rd = 1; reg_addr = a; reg_size = sz;
        #1;
        chk(req, "read", reg_rdata, exp);
        tick();
        reg_rd = 0; reg_size = 2'b10;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1; tick(); sleep_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R14 watchdog actual %h expected %h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        ms = M_RUN; mc7 = 0; mc5 = 0; mbar = 0; mcnt = 0; mpend = 0; mbyrst = 0;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R14: reset state
        chk("R14", "core_clk_en after reset", 32'(core_clk_en), 1);
        rd_expect(4'h0, 2'b10, 32'h0, "R14");
        rd_expect(4'h4, 2'b10, 32'h0, "R14");

        // R1: only bits 7 and 5 stick
        wr(4'h0, 32'hFFFF_FF7F, 2'b10);
        rd_expect(4'h0, 2'b10, 32'h0000_0020, "R1");
        // R2: both bits set is rejected
        wr(4'h0, 32'h0000_00A0, 2'b10);
        rd_expect(4'h0, 2'b10, 32'h0000_0020, "R2");
        // R3: narrow accesses ignored
        wr(4'h0, 32'h0000_0080, 2'b01);
        rd_expect(4'h0, 2'b10, 32'h0000_0020, "R3");
        rd_expect(4'h0, 2'b01, 32'h0, "R3");
        wr(4'h4, 32'h1234_5678, 2'b10);
        rd_expect(4'h4, 2'b10, 32'h1234_5678, "R3");
        wr(4'h4, 32'hFFFF_FFFF, 2'b00);
        rd_expect(4'h4, 2'b10, 32'h1234_5678, "R3");

        // R4 / R5: nap mode and its exits
        wr(4'h0, 32'h0, 2'b10);
        pulse_sleep();
        chk("R4", "nap core clock", 32'(core_clk_en), 0);
        chk("R4", "nap clock out", 32'(clkout_en), 1);
        tick(); tick();
        irq_periph = 1; tick(); irq_periph = 0;
        chk("R5", "nap exit on peripheral irq", 32'(core_clk_en), 1);
        pulse_sleep(); tick();
        sys_rst_req = 1; tick(); sys_rst_req = 0;
        chk("R5", "nap exit on system reset", 32'(core_clk_en), 1);

        // R7: standby-select bit blocks the sleep request
        wr(4'h0, 32'h0000_0080, 2'b10);
        pulse_sleep();
        chk("R7", "ignored sleep request", 32'(core_clk_en), 1);
        tick();

        // R6, R8, R9, R10, R12, R13: retention with interrupt wake
        wr(4'h0, 32'h0000_0020, 2'b10);
        wr(4'h4, 32'h8000_1000, 2'b10);
        pulse_sleep();
        chk("R6", "power-off request", 32'(core_pwr_off), 1);
        chk("R6", "pd status not yet", 32'(pd_status), 0);
        tick();
        chk("R6", "pd status", 32'(pd_status), 1);
        irq_periph = 1; tick(); irq_periph = 0;
        chk("R8", "peripheral irq ignored", 32'(pd_status), 1);
        tick();
        irq_timer = 1; irq_rtc = 1; tick(); irq_timer = 0; irq_rtc = 0;
        begin
            int held = 0;
            while (core_rst && !core_clk_en && held < 50) begin
                held++;
                chk("R12", "pending mask in settle", 32'(wake_src), 32'h14);
                tick();
            end
            chk("R9", "settle length", 32'(held), 32'(SETTLE + 1));
        end
        chk("R10", "restore pulse", 32'(restore_req), 1);
        chk("R10", "status low at restore", 32'(lp_status), 0);
        tick();
        chk("R10", "resume address", wake_vec, 32'h8000_1000);
        chk("R12", "mask held at strobe", 32'(wake_src), 32'h14);
        tick();
        chk("R12", "mask cleared", 32'(wake_src), 0);
        rd_expect(4'h0, 2'b10, 32'h0000_0020, "R13");

        // R11: reset wake beats a same-cycle interrupt
        pulse_sleep(); tick();
        irq_nmi = 1; sys_rst_req = 1; tick(); irq_nmi = 0; sys_rst_req = 0;
        begin
            int guard = 0;
            while (!wake_vec_vld && guard < 50) begin
                guard++;
                chk("R11", "no restore on reset wake", 32'(restore_req), 0);
                tick();
            end
        end
        chk("R11", "reset vector", wake_vec, 32'hA000_0000);
        chk("R11", "no pending source", 32'(wake_src), 0);
        tick();

        // R14: power-on reset in the middle of retention
        pulse_sleep(); tick();
        rst = 1; tick(); rst = 0;
        chk("R14", "run after reset", 32'(core_clk_en), 1);
        rd_expect(4'h4, 2'b10, 32'h0, "R14");
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule